// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the master side of a two-wire synchronous link. It drives the serial clock and takes in words from one data line. A divisor sets the bit rate. The divisor is either 8 bits wide or, when a mode bit selects it, 16 bits formed from a low and a high register byte. Each receive phase of the generated clock lasts divisor+1 system clocks. The idle phase after it lasts the same. The data line is sampled when the clock returns to its idle level.

Software works through a small register port. It writes a control byte and the two divisor bytes. It reads back the control byte, a status byte, the received data and the low divisor byte. There are two receive enables. The single-word enable clears itself once a word is in. The continuous enable keeps the clock running word after word until software clears it. When both are set, continuous operation wins. A word is 8 bits, or 9 bits on request, and the top bit of a 9-bit word goes to a status bit. A completed word raises a done flag, and an interrupt follows when it is enabled. A word that completes while the previous one is still unread sets an overrun flag. The data register then keeps the older word, and no new word starts until the flag is cleared.

Top module: `sync_master_rx`

## Requirements
- R1: After reset, the control byte, status byte, data and low divisor byte all read 0. `ser_clk` is 0 and `irq` is 0.
- R2: Clocking starts only when the port-enable bit (control bit 0) is set and either the single-word enable (bit 1) or the continuous enable (bit 2) is set. Otherwise `ser_clk` stays at its idle level.
- R3: Each bit is sampled at the clock edge that returns `ser_clk` to idle (falling edge when polarity is 0). The first bit received lands in data bit 0.
- R4: The single-word enable receives exactly one word. It then reads back as 0, and the clock stays idle.
- R5: The continuous enable receives words back to back until it is cleared. The word in progress is finished. With both enables set, reception is continuous.
- R6: Control bit 3 selects 9-bit words. The 9th bit is reported in status bit 2, and the data register holds the low 8 bits.
- R7: Status bit 0 (done) sets when a word completes and clears on a read of the data register (read address 2). `irq` is high exactly when done and the interrupt enable (control bit 6) are both set. A data read in the same cycle as a word completion returns the older word and leaves done set with the new one.
- R8: Control bit 4 sets the idle level of `ser_clk`: 0 gives idle low, 1 gives idle high.
- R9: Each clock phase lasts divisor+1 system clocks. The divisor is the low byte (write address 1) when control bit 5 is 0, and {high byte (write address 2), low byte} when it is 1.
- R10: If a word completes while done is set and unread, status bit 1 (overrun) sets and the data keeps the older word. No further word starts until a control write with the continuous enable at 0 clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 divisor low, 2 divisor high |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (a data read clears done) |
| rd_addr | input | 2 | Read address: 0 control, 1 status, 2 data, 3 divisor low |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| ser_clk | output | 1 | Generated serial clock |
| ser_din | input | 1 | Serial data from the slave |
| irq | output | 1 | Receive interrupt |

## Verification
A software read of the data register and the completion of the next word can fall in the same system clock cycle. The bench provokes this in continuous mode. It counts the slave-side clock edges up to the last bit of the second word, then places the data read on the exact cycle in which that bit is sampled. It judges the outcome at the register port: the read must return the first word, and the status must then show done without overrun, with the second word readable afterwards.

// File: rtl/smr_pkg.sv
`timescale 1ns/1ps
package smr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,   // clock parked at idle level
        ST_ACT,    // clock at active level, bit sampled on leaving
        ST_REST,   // idle half between bits of one word
        ST_TAIL    // idle half after the last bit of a word
    } smr_state_e;

    // control byte, bit 0 is port_en
    typedef struct packed {
        logic irq_en;
        logic wide;
        logic pol;
        logic nine;
        logic cont;
        logic one;
        logic port;
    } smr_ctrl_t;

    localparam logic [1:0] WA_CTRL  = 2'd0;
    localparam logic [1:0] WA_DIVLO = 2'd1;
    localparam logic [1:0] WA_DIVHI = 2'd2;

    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_STAT  = 2'd1;
    localparam logic [1:0] RA_DATA  = 2'd2;
    localparam logic [1:0] RA_DIVLO = 2'd3;

endpackage

// File: rtl/smr_baud.sv
`timescale 1ns/1ps
module smr_baud #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              wide,
    input  logic [HALF_W-1:0] div_lo,
    input  logic [HALF_W-1:0] div_hi,
    output logic              tick
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    assign limit = wide ? {div_hi, div_lo} : {{HALF_W{1'b0}}, div_lo};
    assign tick  = !restart && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/smr_fsm.sv
`timescale 1ns/1ps
module smr_fsm
    import smr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            keep,
    input  logic            halt,
    input  logic            nine,
    input  logic            tick,
    input  logic            din,
    output logic            clk_act,
    output logic            busy,
    output logic            restart,
    output logic            word_done,
    output logic [DATA_W:0] word_val
);
    localparam int WMAX = DATA_W + 1;
    localparam int BW   = $clog2(WMAX + 1);

    smr_state_e      state, nxt;
    logic [BW-1:0]   bit_idx;
    logic [BW-1:0]   last_idx;
    logic [WMAX-1:0] shreg;
    logic [WMAX-1:0] full;
    logic            at_last;
    logic            sample;

    assign last_idx  = nine ? BW'(WMAX - 1) : BW'(DATA_W - 1);
    assign at_last   = (bit_idx == last_idx);
    assign sample    = (state == ST_ACT) && tick && !halt;
    assign full      = {din, shreg[WMAX-1:1]};
    assign word_done = sample && at_last;
    assign word_val  = nine ? full : {1'b0, full[WMAX-1:1]};
    assign restart   = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (go) nxt = ST_ACT;
            ST_ACT: begin
                if (halt)      nxt = ST_IDLE;
                else if (tick) nxt = at_last ? ST_TAIL : ST_REST;
            end
            ST_REST: begin
                if (halt)      nxt = ST_IDLE;
                else if (tick) nxt = ST_ACT;
            end
            ST_TAIL: begin
                if (halt)      nxt = ST_IDLE;
                else if (tick) nxt = keep ? ST_ACT : ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs: clock level, bit counter, shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_act <= 1'b0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            clk_act <= (nxt == ST_ACT);
            if (sample) begin
                shreg   <= full;
                bit_idx <= at_last ? '0 : bit_idx + 1'b1;
            end else if (state == ST_IDLE) begin
                bit_idx <= '0;
            end
        end
    end
endmodule

// File: rtl/smr_regs.sv
`timescale 1ns/1ps
module smr_regs
    import smr_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             word_done,
    input  logic [DATA_W:0]  word_val,
    output smr_ctrl_t        ctrl,
    output logic [REG_W-1:0] div_lo,
    output logic [REG_W-1:0] div_hi,
    output logic             done,
    output logic             ovr
);
    localparam int CTRL_W = $bits(smr_ctrl_t);

    logic [DATA_W-1:0] data_q;
    logic              bit8_q;
    logic              take;
    logic              pending;
    logic              wr_ctrl;
    logic              unused_hi;

    assign take      = rd_en && (rd_addr == RA_DATA);
    assign pending   = done && !take;
    assign wr_ctrl   = wr_en && (wr_addr == WA_CTRL);
    assign unused_hi = ^wr_data[REG_W-1:CTRL_W];

    // control and divisor bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            div_lo <= '0;
            div_hi <= '0;
        end else begin
            if (wr_ctrl)
                ctrl <= smr_ctrl_t'(wr_data[CTRL_W-1:0]);
            else if (word_done)
                ctrl.one <= 1'b0;
            if (wr_en && wr_addr == WA_DIVLO) div_lo <= wr_data;
            if (wr_en && wr_addr == WA_DIVHI) div_hi <= wr_data;
        end
    end

    // received word, done and overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            bit8_q <= 1'b0;
            done   <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (word_done) begin
                if (pending) begin
                    ovr <= 1'b1;
                end else begin
                    data_q <= word_val[DATA_W-1:0];
                    bit8_q <= word_val[DATA_W];
                    done   <= 1'b1;
                end
            end else if (take) begin
                done <= 1'b0;
            end
            if (wr_ctrl && !wr_data[2])
                ovr <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            RA_CTRL:  rd_data = REG_W'(ctrl);
            RA_STAT:  rd_data = REG_W'({bit8_q, ovr, done});
            RA_DATA:  rd_data = REG_W'(data_q);
            RA_DIVLO: rd_data = div_lo;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sync_master_rx.sv
`timescale 1ns/1ps
module sync_master_rx
    import smr_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             ser_clk,
    input  logic             ser_din,
    output logic             irq
);
    smr_ctrl_t         ctrl;
    logic [REG_W-1:0]  div_lo, div_hi;
    logic              st_done, st_ovr;
    logic              ctrl_port, ctrl_one, ctrl_cont, ctrl_pol;
    logic              go, keep, halt;
    logic              tick, restart, clk_act, fsm_busy, word_done;
    logic [DATA_W:0]   word_val;

    assign ctrl_port = ctrl.port;
    assign ctrl_one  = ctrl.one;
    assign ctrl_cont = ctrl.cont;
    assign ctrl_pol  = ctrl.pol;

    assign go   = ctrl_port && (ctrl_one || ctrl_cont) && !st_ovr;
    assign keep = ctrl_port && ctrl_cont && !st_ovr;
    assign halt = !ctrl_port;

    assign ser_clk = clk_act ^ ctrl_pol;
    assign irq     = st_done && ctrl.irq_en;

    smr_regs #(.REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .word_done(word_done), .word_val(word_val),
        .ctrl(ctrl), .div_lo(div_lo), .div_hi(div_hi),
        .done(st_done), .ovr(st_ovr)
    );

    smr_baud #(.HALF_W(REG_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .wide(ctrl.wide), .div_lo(div_lo), .div_hi(div_hi), .tick(tick)
    );

    smr_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .go(go), .keep(keep), .halt(halt), .nine(ctrl.nine),
        .tick(tick), .din(ser_din),
        .clk_act(clk_act), .busy(fsm_busy), .restart(restart),
        .word_done(word_done), .word_val(word_val)
    );
endmodule

// File: rtl/smr_checker.sv
`timescale 1ns/1ps
module smr_checker (
    input logic clk,
    input logic rst_n,
    input logic ser_clk,
    input logic pol,
    input logic port,
    input logic one,
    input logic cont,
    input logic busy,
    input logic word_done,
    input logic done,
    input logic ovr
);
    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ser_clk == pol));

    a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(port && (one || cont) && !ovr));

    a_r7_done_from_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(word_done));

    a_r10_ovr_from_collision: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(word_done && done));

    a_r10_hold_while_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !busy) |=> !busy);
endmodule

bind sync_master_rx smr_checker u_smr_chk (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .pol(ctrl_pol),
    .port(ctrl_port), .one(ctrl_one), .cont(ctrl_cont), .busy(fsm_busy),
    .word_done(word_done), .done(st_done), .ovr(st_ovr)
);

// File: tb/test_sync_master_rx.sv
`timescale 1ns/1ps
module test_sync_master_rx;
    localparam logic [7:0] C_PORT = 8'h01, C_ONE = 8'h02, C_CONT = 8'h04,
                           C_NINE = 8'h08, C_POL = 8'h10, C_WIDE = 8'h20,
                           C_IRQ  = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ser_clk, irq;
    logic       ser_din = 1'b0;

    int total = 0, bad = 0;
    int edge_cnt = 0;
    int nbits = 8;
    int bidx = 0;
    logic bpol = 1'b0;
    logic [8:0] tx_q[$];
    logic [8:0] exp_q[$];

    sync_master_rx i_sync_master_rx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ser_clk(ser_clk), .ser_din(ser_din), .irq(irq)
    );

    always #10 clk = ~clk;

    // slave model: new bit after every edge that leaves idle
    initial begin
        logic [8:0] cur;
        cur = '0;
        forever begin
            @(ser_clk);
            if (rst_n && ser_clk !== bpol) begin
                edge_cnt++;
                if (bidx == 0) cur = (tx_q.size() > 0) ? tx_q.pop_front() : 9'h0;
                #1 ser_din = cur[bidx];
                bidx++;
                if (bidx == nbits) bidx = 0;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // driver: word goes to the slave and to the scoreboard
    task automatic send(input logic [8:0] w);
        tx_q.push_back(w);
        exp_q.push_back(w);
    endtask

    task automatic wait_done();
        logic [7:0] s;
        do rd(2'd1, s); while (!s[0]);
    endtask

    // monitor: waits for a word and compares with the scoreboard head
    task automatic take(input string tag);
        logic [7:0] s, d;
        logic [8:0] e;
        do rd(2'd1, s); while (!s[0]);
        rd(2'd2, d);
        e = exp_q.pop_front();
        check({tag, " data"}, d, e[7:0]);
        if (nbits == 9) check({tag, " ninth bit"}, s[2], e[8]);
    endtask

    task automatic run_all();
        logic [7:0] v;
        logic [8:0] e;
        time t1, t2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 ser_clk", ser_clk, 0);
        check("R1 irq", irq, 0);
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 status", v, 0);
        rd(2'd2, v); check("R1 data", v, 0);
        rd(2'd3, v); check("R1 divlo", v, 0);

        wr(2'd1, 8'd3);
        // R2 no port enable, no clock
        send(9'h05A);
        wr(2'd0, C_ONE);
        repeat (40) @(negedge clk);
        check("R2 no edges without port enable", edge_cnt, 0);
        check("R2 clock idle", ser_clk, 0);
        wr(2'd0, C_PORT | C_ONE);
        take("R3 single word lsb first");
        rd(2'd0, v); check("R4 single enable self-clears", v, C_PORT);
        repeat (60) @(negedge clk);
        check("R4 exactly one word of edges", edge_cnt, 8);
        check("R7 irq off when disabled", irq, 0);
        rd(2'd1, v); check("R7 done cleared by data read", v, 0);

        // R7 interrupt
        edge_cnt = 0;
        send(9'h0C3);
        wr(2'd0, C_PORT | C_ONE | C_IRQ);
        wait_done();
        check("R7 irq with done", irq, 1);
        rd(2'd2, v);
        e = exp_q.pop_front();
        check("R7 data", v, e[7:0]);
        @(negedge clk);
        check("R7 irq drops after read", irq, 0);

        // R6 nine bit words
        nbits = 9;
        send(9'h1A5);
        wr(2'd0, C_PORT | C_ONE | C_NINE);
        take("R6 nine bit, top set");
        send(9'h05A);
        wr(2'd0, C_PORT | C_ONE | C_NINE);
        take("R6 nine bit, top clear");
        repeat (20) @(negedge clk);
        nbits = 8;
        wr(2'd0, C_PORT);

        // R5 both enables: continuous wins
        edge_cnt = 0;
        send(9'h011); send(9'h0EE);
        wr(2'd0, C_PORT | C_ONE | C_CONT);
        take("R5 first word");
        rd(2'd0, v); check("R5 continuous kept, single cleared", v, C_PORT | C_CONT);
        wait (edge_cnt >= 9);
        wr(2'd0, C_PORT);
        take("R5 second word");
        repeat (60) @(negedge clk);
        check("R5 stops after clear", edge_cnt, 16);

        // R7 data read on the completion cycle of the next word
        edge_cnt = 0;
        send(9'h03C); send(9'h096);
        wr(2'd0, C_PORT | C_CONT);
        wait (edge_cnt == 16);
        repeat (3) @(negedge clk);
        rd(2'd2, v);
        e = exp_q.pop_front();
        check("R7 coincident read returns older word", v, e[7:0]);
        wr(2'd0, C_PORT);
        rd(2'd1, v); check("R7 coincident: done set, no overrun", v, 8'h01);
        rd(2'd2, v);
        e = exp_q.pop_front();
        check("R7 coincident: newer word kept", v, e[7:0]);
        repeat (40) @(negedge clk);
        check("R5 coincident run stopped", edge_cnt, 16);

        // R10 overrun
        edge_cnt = 0;
        send(9'h0A1); send(9'h07E);
        wr(2'd0, C_PORT | C_CONT);
        wait (edge_cnt == 16);
        repeat (20) @(negedge clk);
        rd(2'd1, v); check("R10 overrun flagged", v, 8'h03);
        repeat (60) @(negedge clk);
        check("R10 no clocking while overrun", edge_cnt, 16);
        check("R10 clock idle", ser_clk, 0);
        wr(2'd0, C_PORT);
        rd(2'd1, v); check("R10 clearing cont clears overrun", v, 8'h01);
        rd(2'd2, v);
        e = exp_q.pop_front();
        check("R10 older word kept", v, e[7:0]);
        void'(exp_q.pop_front());

        // R8 polarity
        bpol = 1'b1;
        wr(2'd0, C_POL);
        check("R8 idle high", ser_clk, 1);
        edge_cnt = 0;
        send(9'h069);
        wr(2'd0, C_PORT | C_ONE | C_POL);
        take("R8 inverted clock word");
        repeat (10) @(negedge clk);
        check("R8 back to idle high", ser_clk, 1);
        bpol = 1'b0;
        wr(2'd0, 8'h00);
        check("R8 idle low", ser_clk, 0);

        // R9 divisor width
        wr(2'd2, 8'd1);
        edge_cnt = 0;
        send(9'h042);
        wr(2'd0, C_PORT | C_ONE);
        wait (edge_cnt == 1); t1 = $time;
        wait (edge_cnt == 2); t2 = $time;
        check("R9 8-bit divisor period", int'((t2 - t1) / 20), 8);
        take("R9 8-bit divisor word");
        edge_cnt = 0;
        send(9'h0BD);
        wr(2'd0, C_PORT | C_ONE | C_WIDE);
        wait (edge_cnt == 1); t1 = $time;
        wait (edge_cnt == 2); t2 = $time;
        check("R9 16-bit divisor period", int'((t2 - t1) / 20), 520);
        take("R9 16-bit divisor word");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule